// File: doc/BRIEF.md
# Single-Cycle Integer Subset Executor

This block executes one 32-bit instruction word per clock cycle for a small integer subset of a fixed-length RISC instruction set. Each word is split into its register-register or immediate fields. The six-bit opcode in the top bits of every format picks the operation. For opcode 0 only, the function field in the low six bits picks it instead. The two source registers are read from a 32-entry register file and the result is computed. The result is written back on the same rising edge, so the next instruction word can use it at once.

The supported operations are:
- register add and register subtract-unsigned;
- add-immediate, in a trapping form and a non-trapping form;
- signed and unsigned set-less-than against an immediate;
- or-immediate and load-upper-immediate.

A full 32-bit constant is built with load-upper-immediate and then or-immediate. Two registered flags report the instruction that was just executed: signed overflow of a trapping add, and an unsupported encoding. A debug select port reads any register without disturbing execution.

Top module: `mx_exec_core`

## Requirements
- R1: A synchronous active-high reset clears all 32 registers to zero and clears both flags.
- R2: Opcode 0 (bits 31:26) with function 32 (bits 5:0) writes rs+rt into rd. rs is bits 25:21, rt is bits 20:16 and rd is bits 15:11. Word 0x012A4020 writes register 9 plus register 10 into register 8.
- R3: Opcode 0 with function 35 writes rs-rt modulo 2^32 into rd, and never raises the overflow flag.
- R4: Opcode 8 writes rs plus the sign-extended 16-bit immediate (bits 15:0) into rt. Word 0x22D5FFCE adds -50 to register 22 and writes the sum into register 21.
- R5: Opcode 9 writes rs plus the sign-extended immediate into rt, and never raises the overflow flag.
- R6: Opcode 10 writes 1 into rt if rs is signed-less-than the sign-extended immediate, and 0 otherwise. Opcode 11 sign-extends the immediate first, then compares both operands as unsigned.
- R7: Opcode 15 writes {imm, 16'h0000} into rt. Opcode 13 writes rs OR the zero-extended immediate into rt. Together they compose 0xABABCDCD from 0xABAB and 0xCDCD.
- R8: Opcodes 0/32 and 8 set the overflow flag on signed overflow and leave the destination unchanged. The flag is registered and shows the instruction presented before the latest rising edge.
- R9: Any other opcode, or opcode 0 with another function, sets the illegal flag for that instruction and writes no register.
- R10: Register 0 always reads zero, and writes aimed at it are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction word executed at the next rising edge |
| dbg_sel | input | 5 | Register index for the debug read |
| dbg_value | output | 32 | Combinational contents of the selected register |
| ovf_flag | output | 1 | Signed overflow of the last trapping add |
| illegal_flag | output | 1 | Last instruction was not a supported encoding |

## Verification
Trapped overflow is the hardest case to reach from the ports. It needs a register that already holds a value near the signed limit. It also needs proof that the destination kept its old contents. The bench first builds 0x7FFFFFFF with load-upper-immediate and or-immediate. It seeds the destination with a known value. It then issues the trapping add forms and reads the destination back through the debug port. The non-trapping forms get the same operands, so the test also shows that they write the wrapped result without a flag.

// File: rtl/mx_pkg.sv
package mx_pkg;
  localparam int INSN_W = 32;
  localparam int IMM_W  = 16;
  localparam int RIDX_W = 5;

  localparam logic [5:0] OPC_REG   = 6'd0;
  localparam logic [5:0] OPC_ADDI  = 6'd8;
  localparam logic [5:0] OPC_ADDIU = 6'd9;
  localparam logic [5:0] OPC_SLTI  = 6'd10;
  localparam logic [5:0] OPC_SLTIU = 6'd11;
  localparam logic [5:0] OPC_ORI   = 6'd13;
  localparam logic [5:0] OPC_LUI   = 6'd15;

  localparam logic [5:0] FN_ADD  = 6'd32;
  localparam logic [5:0] FN_SUBU = 6'd35;

  typedef enum logic [3:0] {
    OP_NONE, OP_ADD, OP_SUBU, OP_ADDI, OP_ADDIU,
    OP_SLTI, OP_SLTIU, OP_ORI, OP_LUI
  } exec_op_e;

  typedef struct packed {
    exec_op_e              op;
    logic [RIDX_W-1:0]     src_a;
    logic [RIDX_W-1:0]     src_b;
    logic [RIDX_W-1:0]     dst;
    logic [IMM_W-1:0]      imm;
    logic                  illegal;
  } dec_t;
endpackage

// File: rtl/mx_decode.sv
module mx_decode
  import mx_pkg::*;
(
  input  logic [INSN_W-1:0] instr,
  output dec_t              dec
);
  logic [5:0] opc;
  logic [5:0] fn;

  assign opc = instr[31:26];
  assign fn  = instr[5:0];

  always_comb begin
    dec.src_a   = instr[25:21];
    dec.src_b   = instr[20:16];
    dec.dst     = instr[20:16];
    dec.imm     = instr[15:0];
    dec.op      = OP_NONE;
    dec.illegal = 1'b0;
    case (opc)
      OPC_REG: begin
        dec.dst = instr[15:11];
        case (fn)
          FN_ADD:  dec.op = OP_ADD;
          FN_SUBU: dec.op = OP_SUBU;
          default: dec.illegal = 1'b1;
        endcase
      end
      OPC_ADDI:  dec.op = OP_ADDI;
      OPC_ADDIU: dec.op = OP_ADDIU;
      OPC_SLTI:  dec.op = OP_SLTI;
      OPC_SLTIU: dec.op = OP_SLTIU;
      OPC_ORI:   dec.op = OP_ORI;
      OPC_LUI:   dec.op = OP_LUI;
      default:   dec.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/mx_alu.sv
module mx_alu
  import mx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  exec_op_e         op,
  input  logic [XLEN-1:0]  opnd_a,
  input  logic [XLEN-1:0]  opnd_b,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  result,
  output logic             trap_ovf
);
  localparam int MSB = XLEN - 1;
  localparam int EXT = XLEN - IMM_W;

  logic [XLEN-1:0] imm_sx;
  logic [XLEN-1:0] imm_zx;
  logic [XLEN-1:0] add_rhs;
  logic [XLEN-1:0] sum;
  logic            sum_ovf;

  assign imm_sx  = {{EXT{imm[IMM_W-1]}}, imm};
  assign imm_zx  = {{EXT{1'b0}}, imm};
  assign add_rhs = (op == OP_ADD) ? opnd_b : imm_sx;
  assign sum     = opnd_a + add_rhs;
  assign sum_ovf = (opnd_a[MSB] == add_rhs[MSB]) && (sum[MSB] != opnd_a[MSB]);

  always_comb begin
    result   = '0;
    trap_ovf = 1'b0;
    case (op)
      OP_ADD, OP_ADDI: begin
        result   = sum;
        trap_ovf = sum_ovf;
      end
      OP_ADDIU: result = sum;
      OP_SUBU:  result = opnd_a - opnd_b;
      OP_SLTI:  result = {{MSB{1'b0}}, ($signed(opnd_a) < $signed(imm_sx))};
      OP_SLTIU: result = {{MSB{1'b0}}, (opnd_a < imm_sx)};
      OP_ORI:   result = opnd_a | imm_zx;
      OP_LUI:   result = {imm, {(XLEN-IMM_W){1'b0}}};
      default:  result = '0;
    endcase
  end
endmodule

// File: rtl/mx_regfile.sv
module mx_regfile #(
  parameter int XLEN  = 32,
  parameter int NREG  = 32,
  parameter int NREAD = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [$clog2(NREG)-1:0]     wa,
  input  logic [XLEN-1:0]             wd,
  input  logic [NREAD-1:0][$clog2(NREG)-1:0] ra,
  output logic [NREAD-1:0][XLEN-1:0]  rd
);
  localparam int AW = $clog2(NREG);

  logic [XLEN-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we && (wa != '0)) begin
      mem[wa] <= wd;
    end
  end

  for (genvar p = 0; p < NREAD; p++) begin : g_rd
    assign rd[p] = (ra[p] == AW'(0)) ? '0 : mem[ra[p]];
  end

  // R10: the zero register keeps its reset value whatever is written.
  a_r10_zero_kept: assert property (@(posedge clk) disable iff (rst)
    mem[0] == '0);

  // R2: an accepted write is visible in storage after the edge.
  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    (we && (wa != '0)) |=> (mem[$past(wa)] == $past(wd)));
endmodule

// File: rtl/mx_exec_core.sv
module mx_exec_core
  import mx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [INSN_W-1:0]   instr,
  input  logic [RIDX_W-1:0]   dbg_sel,
  output logic [XLEN-1:0]     dbg_value,
  output logic                ovf_flag,
  output logic                illegal_flag
);
  localparam int NREG  = 1 << RIDX_W;
  localparam int NREAD = 3;

  dec_t                             dec;
  logic [XLEN-1:0]                  alu_res;
  logic                             alu_ovf;
  logic                             wr_en;
  logic [NREAD-1:0][RIDX_W-1:0]     rd_addr;
  logic [NREAD-1:0][XLEN-1:0]       rd_data;

  mx_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  assign rd_addr[0] = dec.src_a;
  assign rd_addr[1] = dec.src_b;
  assign rd_addr[2] = dbg_sel;
  assign dbg_value  = rd_data[2];

  mx_alu #(.XLEN(XLEN)) u_alu (
    .op       (dec.op),
    .opnd_a   (rd_data[0]),
    .opnd_b   (rd_data[1]),
    .imm      (dec.imm),
    .result   (alu_res),
    .trap_ovf (alu_ovf)
  );

  assign wr_en = !dec.illegal && !alu_ovf;

  mx_regfile #(.XLEN(XLEN), .NREG(NREG), .NREAD(NREAD)) u_rf (
    .clk (clk),
    .rst (rst),
    .we  (wr_en),
    .wa  (dec.dst),
    .wd  (alu_res),
    .ra  (rd_addr),
    .rd  (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag     <= 1'b0;
      illegal_flag <= 1'b0;
    end else begin
      ovf_flag     <= alu_ovf;
      illegal_flag <= dec.illegal;
    end
  end

  // R9: an unsupported word is flagged in the following cycle.
  a_r9_illegal_reported: assert property (@(posedge clk) disable iff (rst)
    dec.illegal |=> (illegal_flag && !ovf_flag));

  // R9: decoder rejection and ALU overflow never coincide.
  a_r9_no_ovf_on_illegal: assert property (@(posedge clk) disable iff (rst)
    dec.illegal |-> !alu_ovf);

  // R8: a trapped add is reported after the edge.
  a_r8_ovf_reported: assert property (@(posedge clk) disable iff (rst)
    alu_ovf |=> ovf_flag);

  // R3 and R5: the non-trapping arithmetic forms never overflow.
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    ((dec.op == OP_SUBU) || (dec.op == OP_ADDIU)) |-> !alu_ovf);

  // R7: the upper-immediate load leaves the low half clear.
  a_r7_lui_low_clear: assert property (@(posedge clk) disable iff (rst)
    (dec.op == OP_LUI) |-> (alu_res[IMM_W-1:0] == '0));

  // R6: the compare forms produce only 0 or 1.
  a_r6_slt_boolean: assert property (@(posedge clk) disable iff (rst)
    ((dec.op == OP_SLTI) || (dec.op == OP_SLTIU)) |-> (alu_res[XLEN-1:1] == '0));
endmodule

// File: tb/mx_exec_core_tb.sv
module mx_exec_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] NOP = 32'h0000_0020;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = NOP;
  logic [4:0]  dbg_sel = '0;
  logic [31:0] dbg_value;
  logic        ovf_flag;
  logic        illegal_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mx_exec_core u_dut (
    .clk          (clk),
    .rst          (rst),
    .instr        (instr),
    .dbg_sel      (dbg_sel),
    .dbg_value    (dbg_value),
    .ovf_flag     (ovf_flag),
    .illegal_flag (illegal_flag)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction

  function automatic logic [31:0] enc_i(int opc, int rs, int rt, logic [15:0] imm);
    return {6'(opc), 5'(rs), 5'(rt), imm};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // Presents one word for exactly one rising edge; returns at the following falling edge.
  task automatic exec(logic [31:0] w);
    instr = w;
    @(negedge clk);
    instr = NOP;
  endtask

  task automatic check_reg(string req, int r, logic [31:0] exp);
    dbg_sel = 5'(r);
    #1;
    check(req, $sformatf("reg %0d", r), dbg_value, exp);
  endtask

  task automatic check_flags(string req, logic ovf, logic ill);
    check(req, "ovf_flag", {31'd0, ovf_flag}, {31'd0, ovf});
    check(req, "illegal_flag", {31'd0, illegal_flag}, {31'd0, ill});
  endtask

  task automatic load_const(int r, logic [31:0] v);
    exec(enc_i(15, 0, r, v[31:16]));
    exec(enc_i(13, r, r, v[15:0]));
  endtask

  task automatic t_reset_state();
    check_flags("R1", 1'b0, 1'b0);
    check_reg("R1", 1, 32'h0);
    check_reg("R1", 8, 32'h0);
    check_reg("R1", 31, 32'h0);
  endtask

  task automatic t_upper_or();
    exec(enc_i(15, 0, 8, 16'hABAB));
    check_reg("R7", 8, 32'hABAB_0000);
    exec(enc_i(13, 8, 8, 16'hCDCD));
    check_reg("R7", 8, 32'hABAB_CDCD);
    exec(enc_i(13, 0, 2, 16'h8000));
    check_reg("R7 zero-extend", 2, 32'h0000_8000);
    check_flags("R7", 1'b0, 1'b0);
  endtask

  task automatic t_reg_add();
    load_const(9, 32'd5);
    load_const(10, 32'd7);
    exec(32'h012A_4020);
    check_reg("R2", 8, 32'd12);
    check_flags("R2", 1'b0, 1'b0);
    load_const(9, 32'hFFFF_FFFF);
    exec(32'h012A_4020);
    check_reg("R2 signed mix", 8, 32'd6);
  endtask

  task automatic t_add_imm();
    load_const(22, 32'd100);
    exec(32'h22D5_FFCE);
    check_reg("R4", 21, 32'd50);
    exec(enc_i(8, 22, 21, 16'h0010));
    check_reg("R4 positive", 21, 32'd116);
    check_flags("R4", 1'b0, 1'b0);
  endtask

  task automatic t_subu();
    load_const(1, 32'd3);
    load_const(2, 32'd5);
    exec(enc_r(1, 2, 3, 35));
    check_reg("R3", 3, 32'hFFFF_FFFE);
    check_flags("R3", 1'b0, 1'b0);
    load_const(5, 32'h8000_0000);
    load_const(6, 32'd1);
    exec(enc_r(5, 6, 7, 35));
    check_reg("R3 wrap", 7, 32'h7FFF_FFFF);
    check_flags("R3 wrap", 1'b0, 1'b0);
  endtask

  task automatic t_addiu();
    load_const(5, 32'h7FFF_FFFF);
    exec(enc_i(9, 5, 6, 16'h0001));
    check_reg("R5", 6, 32'h8000_0000);
    check_flags("R5", 1'b0, 1'b0);
    exec(enc_i(9, 0, 7, 16'hFFFF));
    check_reg("R5 sign-extend", 7, 32'hFFFF_FFFF);
  endtask

  task automatic t_compare();
    load_const(3, 32'hFFFF_FFFE);
    load_const(1, 32'd3);
    exec(enc_i(10, 3, 4, 16'h0001));
    check_reg("R6 signed", 4, 32'd1);
    exec(enc_i(11, 3, 4, 16'h0001));
    check_reg("R6 unsigned", 4, 32'd0);
    exec(enc_i(11, 1, 4, 16'hFFFF));
    check_reg("R6 unsigned sext", 4, 32'd1);
    exec(enc_i(10, 1, 4, 16'hFFFF));
    check_reg("R6 signed neg", 4, 32'd0);
  endtask

  task automatic t_overflow();
    load_const(5, 32'h7FFF_FFFF);
    load_const(9, 32'h1234_5678);
    exec(enc_r(5, 5, 9, 32));
    check_flags("R8 add", 1'b1, 1'b0);
    check_reg("R8 add kept", 9, 32'h1234_5678);
    exec(enc_i(8, 5, 9, 16'h0001));
    check_flags("R8 addi", 1'b1, 1'b0);
    check_reg("R8 addi kept", 9, 32'h1234_5678);
    load_const(6, 32'h8000_0000);
    exec(enc_i(8, 6, 9, 16'hFFFF));
    check_flags("R8 neg", 1'b1, 1'b0);
    check_reg("R8 neg kept", 9, 32'h1234_5678);
    exec(NOP);
    check_flags("R8 clears", 1'b0, 1'b0);
  endtask

  task automatic t_illegal();
    load_const(9, 32'hCAFE_0001);
    exec(enc_i(35, 0, 9, 16'h0004));
    check_flags("R9 opcode", 1'b0, 1'b1);
    check_reg("R9 opcode", 9, 32'hCAFE_0001);
    exec(enc_r(1, 2, 9, 33));
    check_flags("R9 funct", 1'b0, 1'b1);
    check_reg("R9 funct", 9, 32'hCAFE_0001);
    exec(NOP);
    check_flags("R9 clears", 1'b0, 1'b0);
  endtask

  task automatic t_zero_reg();
    exec(enc_i(13, 0, 0, 16'h1234));
    check_reg("R10 ori", 0, 32'h0);
    exec(enc_i(15, 0, 0, 16'hFFFF));
    check_reg("R10 lui", 0, 32'h0);
    exec(enc_i(9, 0, 4, 16'h0000));
    check_reg("R10 source", 4, 32'h0);
  endtask

  task automatic t_reset_again();
    rst = 1'b1;
    exec(NOP);
    rst = 1'b0;
    check_reg("R1 rerun", 8, 32'h0);
    check_reg("R1 rerun", 21, 32'h0);
    check_flags("R1 rerun", 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_upper_or();
    t_reg_add();
    t_add_imm();
    t_subu();
    t_addiu();
    t_compare();
    t_overflow();
    t_illegal();
    t_zero_reg();
    exec(enc_i(13, 0, 3, 16'h00FF));
    t_reset_again();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule